// File: doc/BRIEF.md
# Dual-Bank Flash Address Decoder and Block Protector

This block sits between the host address bus and a two-bank flash array. It turns a 20-bit word address into a flat block number and a bank identifier. One bank holds eight small 16K-word blocks: a boot block and seven parameter blocks. The other bank holds twenty-eight large 32K-word main blocks. An elaboration parameter puts the small blocks either at the bottom or at the top of the address space.

The block keeps one lock bit per block. From that bit, the write-protect pin and the reset/power-down pin it decides whether a requested program or erase may go ahead. It also tells the read path whether a read should come from the array or from the status register. A read aimed at the bank that is busy with a command or an operation gets status. A read aimed at the idle bank gets array data, so reads can continue during background work.

Lock-bit programming is a simple write strobe. All outputs are registered and appear one clock after the inputs that produce them.

Top module: `dbank_guard`

## Requirements
- R1: With `TOP_BOOT=0`, addresses 00000h–1FFFFh map to blocks 0–7 (16K words each, number = addr/4000h) in bank 0. Addresses 20000h–FFFFFh map to blocks 8–35 (32K words each, number = 8 + (addr−20000h)/8000h) in bank 1.
- R2: With `TOP_BOOT=1`, addresses 00000h–DFFFFh map to blocks 0–27 (number = addr/8000h) in bank 1. Addresses E0000h–FFFFFh map to blocks 28–35 (number = 28 + (addr−E0000h)/4000h) in bank 0, and block 35 is the boot block.
- R3: `bank_id` is 0 for every small-block address and 1 for every large-block address.
- R4: `rd_status` is 1 exactly when `busy_vld` is 1 and `busy_bank` equals the decoded bank; otherwise reads go to the array (`rd_status`=0).
- R5: With `wp_n`=0, a request (`op_req`=1) to a block whose lock bit is 0 gives `permit`=0; an unlocked block gives `permit`=1.
- R6: With `wp_n`=1 and `rp_n`=1, every request gives `permit`=1 regardless of lock bits.
- R7: A permitted erase (`op_req`=1, `op_erase`=1) with `wp_n`=1 sets the addressed block's lock bit to 1.
- R8: `lock_dq` bit 6 reports the addressed block's lock bit (1 = unlocked, 0 = locked). All other bits of `lock_dq` are 0.
- R9: While `rp_n`=0, every block reads as locked (`lock_dq`=0) and `permit`=0, and `lock_wr` has no effect.
- R10: After `rst_n` all lock bits are 1 (unlocked). While in reset, all outputs are 0.
- R11: All outputs are registered: they reflect the inputs and lock state from the previous clock edge. A lock write (`lock_wr`=1 with `op_req`=0 and `rp_n`=1) clears the addressed block's bit to 0 at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; lock bits go to 1 |
| rp_n | input | 1 | Reset/power-down pin; low treats all blocks as locked |
| wp_n | input | 1 | Write-protect pin; high overrides lock bits |
| addr | input | 20 | Word address |
| busy_vld | input | 1 | A bank is busy with a command or operation |
| busy_bank | input | 1 | Which bank is busy (0 small-block, 1 main) |
| op_req | input | 1 | Program or erase request for the addressed block |
| op_erase | input | 1 | Request is an erase |
| lock_wr | input | 1 | Lock the addressed block |
| blk_num | output | 6 | Flat block number |
| bank_id | output | 1 | Bank of the addressed block |
| permit | output | 1 | Program/erase allowed |
| rd_status | output | 1 | Read from status register instead of array |
| lock_dq | output | 16 | Lock status word, bit 6 = unlocked |

## Verification
The assertions assume that `addr` and the control inputs are known and steady through each clock edge, and that `busy_bank` matters only while `busy_vld` is high. The bench changes every input just after the falling edge and holds it through the next rising edge. It mixes fixed sequences that lock, erase and read back particular blocks with pseudo-random addresses and controls over the whole 20-bit space. It runs both layouts side by side against a behavioural model.

// File: rtl/dbank_pkg.sv
package dbank_pkg;
  // Flat block number of a word address; small blocks first or last per layout
  function automatic int unsigned blk_of(input int unsigned a, input bit top,
                                         input int unsigned aw, input int unsigned ns,
                                         input int unsigned nl, input int unsigned ss,
                                         input int unsigned ls);
    int unsigned span, base;
    span = ns << ss;
    base = (1 << aw) - span;
    if (top) begin
      if (a >= base) return nl + ((a - base) >> ss);
      return a >> ls;
    end
    if (a < span) return a >> ss;
    return ns + ((a - span) >> ls);
  endfunction

  function automatic bit is_small(input int unsigned a, input bit top,
                                  input int unsigned aw, input int unsigned ns,
                                  input int unsigned ss);
    int unsigned span;
    span = ns << ss;
    return top ? (a >= ((1 << aw) - span)) : (a < span);
  endfunction
endpackage

// File: rtl/blk_decode.sv
module blk_decode #(
  parameter int AW = 20,
  parameter bit TOP_BOOT = 1'b1,
  parameter int NS = 8,
  parameter int NL = 28,
  parameter int SS = 14,
  parameter int LS = 15,
  parameter int BW = 6
) (
  input  logic [AW-1:0] addr,
  output logic [BW-1:0] blk,
  output logic          bank
);
  import dbank_pkg::*;
  localparam int SMALL_LO = TOP_BOOT ? NL : 0;
  localparam int SMALL_HI = SMALL_LO + NS - 1;

  always_comb begin
    blk  = BW'(blk_of(32'(addr), TOP_BOOT, AW, NS, NL, SS, LS));
    bank = !is_small(32'(addr), TOP_BOOT, AW, NS, SS);
  end

  // small-block bank must land in the small-block number range
  always_comb begin
    if (bank == 1'b0)
      p_bank_range_r3: assert (int'(blk) >= SMALL_LO && int'(blk) <= SMALL_HI);
  end
endmodule

// File: rtl/lock_bank.sv
module lock_bank #(
  parameter int NB = 36,
  parameter int BW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] idx,
  input  logic          unlock_en,
  input  logic          lock_en,
  output logic          sel_bit
);
  logic [NB-1:0] q;

  for (genvar g = 0; g < NB; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)                             q[g] <= 1'b1;
      else if (unlock_en && int'(idx) == g)   q[g] <= 1'b1;
      else if (lock_en && int'(idx) == g)     q[g] <= 1'b0;
    end
    p_unlock_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (unlock_en && int'(idx) == g) |=> q[g]);
    p_lock_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_en && !unlock_en && int'(idx) == g) |=> !q[g]);
  end

  always_comb begin
    sel_bit = 1'b0;
    for (int i = 0; i < NB; i++)
      if (int'(idx) == i) sel_bit = q[i];
  end

  p_one_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(q ^ $past(q)) <= 1);
endmodule

// File: rtl/prot_gate.sv
module prot_gate (
  input  logic rp_n,
  input  logic wp_n,
  input  logic req,
  input  logic erase,
  input  logic lock_wr,
  input  logic lock_bit,
  output logic permit,
  output logic unlock_en,
  output logic lock_en,
  output logic lock_vis
);
  always_comb begin
    permit    = req && rp_n && (wp_n || lock_bit);
    unlock_en = permit && erase && wp_n;
    lock_en   = lock_wr && !req && rp_n;
    lock_vis  = rp_n && lock_bit;
  end

  always_comb begin
    if (req && !wp_n && !lock_bit)
      p_wp_locked_r5: assert (!permit);
  end
endmodule

// File: rtl/dbank_guard.sv
module dbank_guard #(
  parameter int AW = 20,
  parameter bit TOP_BOOT = 1'b1,
  parameter int NS = 8,
  parameter int NL = 28,
  parameter int SS = 14,
  parameter int LS = 15,
  parameter int DW = 16,
  parameter int LOCK_POS = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rp_n,
  input  logic             wp_n,
  input  logic [AW-1:0]    addr,
  input  logic             busy_vld,
  input  logic             busy_bank,
  input  logic             op_req,
  input  logic             op_erase,
  input  logic             lock_wr,
  output logic [5:0]       blk_num,
  output logic             bank_id,
  output logic             permit,
  output logic             rd_status,
  output logic [DW-1:0]    lock_dq
);
  localparam int NB = NS + NL;
  localparam int BW = $clog2(NB);

  logic [BW-1:0] dec_blk;
  logic          dec_bank, lock_bit, permit_nx, unlock_en, lock_en, lock_vis, route_nx;

  blk_decode #(.AW(AW), .TOP_BOOT(TOP_BOOT), .NS(NS), .NL(NL), .SS(SS), .LS(LS), .BW(BW))
    u_dec (.addr(addr), .blk(dec_blk), .bank(dec_bank));

  lock_bank #(.NB(NB), .BW(BW))
    u_lock (.clk(clk), .rst_n(rst_n), .idx(dec_blk), .unlock_en(unlock_en),
            .lock_en(lock_en), .sel_bit(lock_bit));

  prot_gate u_gate (.rp_n(rp_n), .wp_n(wp_n), .req(op_req), .erase(op_erase),
                    .lock_wr(lock_wr), .lock_bit(lock_bit), .permit(permit_nx),
                    .unlock_en(unlock_en), .lock_en(lock_en), .lock_vis(lock_vis));

  assign route_nx = busy_vld && (busy_bank == dec_bank);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_num   <= '0;
      bank_id   <= 1'b0;
      permit    <= 1'b0;
      rd_status <= 1'b0;
      lock_dq   <= '0;
    end else begin
      blk_num   <= 6'(dec_blk);
      bank_id   <= dec_bank;
      permit    <= permit_nx;
      rd_status <= route_nx;
      lock_dq   <= DW'({31'd0, lock_vis}) << LOCK_POS;
    end
  end

  p_permit_rp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    permit |-> $past(rp_n));
  p_route_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status |-> $past(busy_vld));
  p_wp_override_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_req && rp_n && wp_n) |=> permit);
endmodule

// File: tb/sim_dbank_guard.sv
module sim_dbank_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0, rp_n = 1'b1, wp_n = 1'b0;
  logic [19:0] addr = '0;
  logic busy_vld = 1'b0, busy_bank = 1'b0, op_req = 1'b0, op_erase = 1'b0, lock_wr = 1'b0;
  logic [5:0] blk0, blk1;
  logic bank0, bank1, perm0, perm1, rs0, rs1;
  logic [15:0] dq0, dq1;
  int checks = 0, errors = 0;
  bit lk0 [36];
  bit lk1 [36];
  int eb [2], ebank [2], eperm [2], ers [2], edq [2];

  always #2 clk = ~clk;

  dbank_guard #(.TOP_BOOT(1'b1)) u0 (.clk(clk), .rst_n(rst_n), .rp_n(rp_n), .wp_n(wp_n),
    .addr(addr), .busy_vld(busy_vld), .busy_bank(busy_bank), .op_req(op_req),
    .op_erase(op_erase), .lock_wr(lock_wr), .blk_num(blk0), .bank_id(bank0),
    .permit(perm0), .rd_status(rs0), .lock_dq(dq0));
  dbank_guard #(.TOP_BOOT(1'b0)) u1 (.clk(clk), .rst_n(rst_n), .rp_n(rp_n), .wp_n(wp_n),
    .addr(addr), .busy_vld(busy_vld), .busy_bank(busy_bank), .op_req(op_req),
    .op_erase(op_erase), .lock_wr(lock_wr), .blk_num(blk1), .bank_id(bank1),
    .permit(perm1), .rd_status(rs1), .lock_dq(dq1));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // model: top layout (L=0) and bottom layout (L=1)
  task automatic predict(input int L);
    int a, b, sm, lkb;
    a = int'(addr);
    if (L == 0) begin
      sm = (a >= 'hE0000);
      b = sm ? 28 + (a - 'hE0000) / 'h4000 : a / 'h8000;
    end else begin
      sm = (a < 'h20000);
      b = sm ? a / 'h4000 : 8 + (a - 'h20000) / 'h8000;
    end
    lkb = (L == 0) ? lk0[b] : lk1[b];
    eb[L] = b;
    ebank[L] = sm ? 0 : 1;
    eperm[L] = (op_req && rp_n && (wp_n || lkb)) ? 1 : 0;
    ers[L] = (busy_vld && (int'(busy_bank) == ebank[L])) ? 1 : 0;
    edq[L] = (rp_n && lkb) ? 'h40 : 0;
    if (eperm[L] == 1 && op_erase && wp_n) begin
      if (L == 0) lk0[b] = 1'b1; else lk1[b] = 1'b1;
    end else if (lock_wr && !op_req && rp_n) begin
      if (L == 0) lk0[b] = 1'b0; else lk1[b] = 1'b0;
    end
  endtask

  // one cycle: inputs already set after a falling edge; compare after next rising edge (R11)
  task automatic step();
    predict(0);
    predict(1);
    @(posedge clk);
    @(negedge clk);
    chk("R2 blk top R11", int'(blk0), eb[0]);
    chk("R1 blk bottom R11", int'(blk1), eb[1]);
    chk("R3 bank top", int'(bank0), ebank[0]);
    chk("R3 bank bottom", int'(bank1), ebank[1]);
    chk("R5 R6 R9 permit top", int'(perm0), eperm[0]);
    chk("R5 R6 R9 permit bottom", int'(perm1), eperm[1]);
    chk("R4 route top", int'(rs0), ers[0]);
    chk("R4 route bottom", int'(rs1), ers[1]);
    chk("R8 R9 lock_dq top", int'(dq0), edq[0]);
    chk("R8 R9 lock_dq bottom", int'(dq1), edq[1]);
  endtask

  task automatic idle();
    op_req = 0; op_erase = 0; lock_wr = 0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 36; i++) begin lk0[i] = 1'b1; lk1[i] = 1'b1; end
    repeat (3) @(negedge clk);
    // R10: outputs cleared while in reset
    chk("R10 reset outputs top", int'({blk0, bank0, perm0, rs0, dq0}), 0);
    chk("R10 reset outputs bottom", int'({blk1, bank1, perm1, rs1, dq1}), 0);
    rst_n = 1'b1;
    // R10: every block unlocked after reset, probed at each small-block step
    for (int a = 0; a < 'h100000; a += 'h4000) begin
      addr = 20'(a); step();
      chk("R10 unlocked after reset", int'(dq0[6] & dq1[6]), 1);
    end
    // boundary addresses R1 R2
    addr = 20'h1FFFF; step();
    chk("R1 last small block bottom", int'(blk1), 7);
    addr = 20'h20000; step();
    chk("R1 first main block bottom", int'(blk1), 8);
    addr = 20'hDFFFF; step();
    chk("R2 last main block top", int'(blk0), 27);
    addr = 20'hFFFFF; step();
    chk("R2 boot block top", int'(blk0), 35);
    // lock then protected request R5, R11
    addr = 20'hFC000; lock_wr = 1; step(); idle();
    step();
    chk("R11 lock written", int'(dq0[6]), 0);
    wp_n = 0; op_req = 1; step();
    chk("R5 locked block rejected", int'(perm0), 0);
    // R6 override then R7 erase unlocks
    wp_n = 1; op_erase = 1; step();
    chk("R6 override permits", int'(perm0), 1);
    idle(); wp_n = 0; step();
    chk("R7 erase restored lock bit", int'(dq0[6]), 1);
    // R9: reset pin low
    lock_wr = 1; rp_n = 0; step(); idle();
    chk("R9 locked view", int'(dq0), 0);
    rp_n = 1; step();
    chk("R9 lock_wr ignored", int'(dq0[6]), 1);
    // R4 routing
    busy_vld = 1; busy_bank = 0; addr = 20'hE4000; step();
    chk("R4 busy bank gives status", int'(rs0), 1);
    addr = 20'h00000; step();
    chk("R4 idle bank gives array", int'(rs0), 0);
    // mixed stimulus
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      addr = 20'(r);
      rp_n = (r[20] | r[21]);
      wp_n = r[22];
      busy_vld = r[23]; busy_bank = r[24];
      op_req = r[25] & r[26]; op_erase = r[27];
      lock_wr = r[28] | r[29];
      step();
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule